// File: doc/BRIEF.md
# Frame buffer DMA fetcher

This block is the read-DMA engine in front of a raster display controller's pixel FIFO. It walks memory windows, each bounded by a base byte address and an inclusive ceiling byte address. It cuts each window into bursts for a simple burst-read master port and forwards every returned word to the FIFO side. Each word is tagged as palette or pixel data and with the frame buffer it came from. Single pulses mark the end of buffer 0, the end of buffer 1, and the completion of a palette load.

A two-bit load mode selects what is fetched after enable:
- Palette then pixel frames.
- Palette alone, after which the engine parks until the enable is dropped.
- Pixel frames alone.

Frames either repeat from buffer 0 or, with the dual-buffer bit set, alternate between buffer 0 and buffer 1. Window addresses are captured at each window start, so software can rewrite the address inputs at end-of-frame without tearing the frame being fetched. All addresses are byte addresses of 32-bit words (multiples of 4), and every ceiling is the window's last byte.

Top module: `fbdma_fetch`

## Requirements
- R1: While reset is held and after it is released with the enable low, `rd_req`, `out_valid`, `busy` and the three event outputs are 0.
- R2: `cfg_burst_code` values 0, 1, 2, 3 and 4 give bursts of 1, 2, 4, 8 and 16 words; codes 5 to 7 give 16 words. The code is captured when the engine starts.
- R3: A window fetches every word from base up to and including the word holding the ceiling byte: (ceiling - base)/4 + 1 words, in rising address order.
- R4: No burst reaches past the ceiling. The final burst of a window is shortened to end exactly at it.
- R5: With `cfg_dual` = 0, only the buffer 0 window is fetched, repeating from its base, and only `evt_eof0` pulses.
- R6: With `cfg_dual` = 1, frames alternate between buffer 0 and buffer 1, starting with buffer 0, and `out_buf` carries 0 or 1 accordingly. `evt_eof0` or `evt_eof1` pulses for one cycle in the same cycle as the last word of that buffer on `out_valid`.
- R7: With `cfg_load_mode` = 0, the palette window is fetched first with `out_pal` = 1. `evt_pal_done` pulses with its last word, and pixel frames from buffer 0 follow.
- R8: With `cfg_load_mode` = 1, only the palette is fetched. The engine then issues no request and `busy` stays 0 while the enable remains high.
- R9: With `cfg_load_mode` = 2 or 3, no palette is fetched; the first word comes from buffer 0's base.
- R10: The palette window is 32 bytes (8 words) when `cfg_pal_wide` = 0 and 512 bytes (128 words) when it is 1, starting at `cfg_pal_base`.
- R11: Base and ceiling inputs are sampled only at the edge where a window starts. A change during a frame has no effect until the next frame. A change present at the edge that accepts a frame's last word applies to the very next frame.
- R12: Clearing `cfg_en` lets the current burst deliver all its words, then the engine goes idle with no further request.
- R13: While `rd_req` is high and `rd_gnt` is low, `rd_req`, `rd_addr` and `rd_len` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Run enable |
| cfg_dual | input | 1 | Alternate between buffer 0 and buffer 1 |
| cfg_load_mode | input | 2 | 0 palette then pixels, 1 palette only, 2/3 pixels only |
| cfg_pal_wide | input | 1 | 0: 32-byte palette, 1: 512-byte palette |
| cfg_burst_code | input | 3 | Burst length code (log2 of words, capped) |
| cfg_base0 | input | AW | Buffer 0 first byte address |
| cfg_ceil0 | input | AW | Buffer 0 last byte address (inclusive) |
| cfg_base1 | input | AW | Buffer 1 first byte address |
| cfg_ceil1 | input | AW | Buffer 1 last byte address (inclusive) |
| cfg_pal_base | input | AW | Palette first byte address |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | AW | Burst start byte address |
| rd_len | output | LENW | Burst length in words |
| rd_gnt | input | 1 | Request accepted this cycle |
| rd_valid | input | 1 | Read data word valid |
| rd_data | input | DW | Read data word |
| out_valid | output | 1 | Word valid toward the FIFO |
| out_data | output | DW | Word toward the FIFO |
| out_pal | output | 1 | Word belongs to the palette |
| out_buf | output | 1 | Frame buffer the word came from |
| evt_eof0 | output | 1 | Buffer 0 window finished |
| evt_eof1 | output | 1 | Buffer 1 window finished |
| evt_pal_done | output | 1 | Palette window finished |
| busy | output | 1 | A burst is requested or in flight |

## Verification
The sharpest coincidence is the end of a frame and the capture of the next window's addresses, which fall on the same clock edge. The bench rewrites the buffer 0 base and ceiling while the frame's last word is on the read bus and expects the very next frame to start at the new base. A rewrite made a few words into a frame must instead leave that frame untouched. A second coincidence, the palette-done pulse next to the first pixel request, is judged by the position of the pulse in the word stream and by the address of the word that follows it.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA,
        ST_HALT
    } fetch_st_e;

    localparam logic [1:0] LM_PAL_PIX  = 2'd0;
    localparam logic [1:0] LM_PAL_ONLY = 2'd1;

    localparam int unsigned PAL_ENTRY_BYTES   = 2;
    localparam int unsigned PAL_SMALL_ENTRIES = 16;
    localparam int unsigned PAL_LARGE_ENTRIES = 256;

endpackage

// File: rtl/fbdma_len_calc.sv
module fbdma_len_calc #(
    parameter int unsigned AW       = 32,
    parameter int unsigned MAX_LOG2 = 4,
    parameter int unsigned LENW     = MAX_LOG2 + 1
) (
    input  logic [AW-1:0]   cur_addr,
    input  logic [AW-1:0]   win_ceil,
    input  logic [2:0]      size_code,
    output logic [LENW-1:0] burst_len,
    output logic            last_burst
);
    logic [AW-1:0] remain;
    logic [AW-1:0] cap;
    int unsigned   lg;

    always_comb begin
        remain = ((win_ceil - cur_addr) >> 2) + AW'(1);
        lg     = (int'(size_code) > int'(MAX_LOG2)) ? MAX_LOG2 : int'(size_code);
        cap    = AW'(1) << lg;
        if (remain <= cap) begin
            burst_len  = remain[LENW-1:0];
            last_burst = 1'b1;
        end else begin
            burst_len  = cap[LENW-1:0];
            last_burst = 1'b0;
        end
    end
endmodule

// File: rtl/fbdma_beat_cnt.sv
module fbdma_beat_cnt #(
    parameter int unsigned LENW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [LENW-1:0] load_len,
    input  logic            beat,
    output logic            burst_done
);
    typedef struct packed {
        logic            active;
        logic [LENW-1:0] len;
        logic [LENW-1:0] cnt;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d          = q;
        burst_done = q.active && beat && ((q.cnt + LENW'(1)) == q.len);
        if (load) begin
            d.active = 1'b1;
            d.len    = load_len;
            d.cnt    = '0;
        end else if (q.active && beat) begin
            if (burst_done) d.active = 1'b0;
            else            d.cnt    = q.cnt + LENW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !q.active); // R12

    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |-> (q.cnt < q.len)); // R4
endmodule

// File: rtl/fbdma_seq.sv
module fbdma_seq
    import fbdma_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned LENW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            dual,
    input  logic [1:0]      mode,
    input  logic            pal_wide,
    input  logic [2:0]      size_code,
    input  logic [AW-1:0]   base0,
    input  logic [AW-1:0]   ceil0,
    input  logic [AW-1:0]   base1,
    input  logic [AW-1:0]   ceil1,
    input  logic [AW-1:0]   pal_base,
    input  logic            rd_gnt,
    input  logic            burst_done,
    input  logic [LENW-1:0] burst_len,
    input  logic            last_burst,
    output logic            rd_req,
    output logic [AW-1:0]   cur_addr,
    output logic [AW-1:0]   cur_ceil,
    output logic [2:0]      code_o,
    output logic            cnt_load,
    output logic            is_pal,
    output logic            buf_sel,
    output logic            evt_eof0,
    output logic            evt_eof1,
    output logic            evt_pal,
    output logic            busy
);
    localparam int unsigned SMALL_BYTES = PAL_SMALL_ENTRIES * PAL_ENTRY_BYTES;
    localparam int unsigned LARGE_BYTES = PAL_LARGE_ENTRIES * PAL_ENTRY_BYTES;

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] addr;
        logic [AW-1:0] ceil;
        logic          pal;
        logic          bsel;
        logic [2:0]    code;
        logic [1:0]    mode;
        logic          last;
        logic          eof0;
        logic          eof1;
        logic          pald;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d        = q;
        d.eof0   = 1'b0;
        d.eof1   = 1'b0;
        d.pald   = 1'b0;
        rd_req   = 1'b0;
        cnt_load = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (en) begin
                    d.code = size_code;
                    d.mode = mode;
                    d.bsel = 1'b0;
                    if (mode == LM_PAL_PIX || mode == LM_PAL_ONLY) begin
                        d.addr = pal_base;
                        d.ceil = pal_base + (pal_wide ? AW'(LARGE_BYTES - 1)
                                                      : AW'(SMALL_BYTES - 1));
                        d.pal  = 1'b1;
                    end else begin
                        d.addr = base0;
                        d.ceil = ceil0;
                        d.pal  = 1'b0;
                    end
                    d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                rd_req = 1'b1;
                if (rd_gnt) begin
                    cnt_load = 1'b1;
                    d.last   = last_burst;
                    d.addr   = q.addr + (AW'(burst_len) << 2);
                    d.st     = ST_DATA;
                end
            end
            ST_DATA: begin
                if (burst_done) begin
                    d.st = en ? ST_REQ : ST_IDLE;
                    if (q.last) begin
                        if (q.pal) begin
                            d.pald = 1'b1;
                            if (q.mode == LM_PAL_ONLY) begin
                                d.st = ST_HALT;
                            end else begin
                                d.addr = base0;
                                d.ceil = ceil0;
                                d.pal  = 1'b0;
                                d.bsel = 1'b0;
                            end
                        end else begin
                            d.eof0 = !q.bsel;
                            d.eof1 = q.bsel;
                            d.bsel = dual ? !q.bsel : 1'b0;
                            d.addr = d.bsel ? base1 : base0;
                            d.ceil = d.bsel ? ceil1 : ceil0;
                        end
                    end
                end
            end
            default: begin
                if (!en) d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cur_addr = q.addr;
    assign cur_ceil = q.ceil;
    assign code_o   = q.code;
    assign is_pal   = q.pal;
    assign buf_sel  = q.bsel;
    assign evt_eof0 = q.eof0;
    assign evt_eof1 = q.eof1;
    assign evt_pal  = q.pald;
    assign busy     = (q.st == ST_REQ) || (q.st == ST_DATA);

    logic [AW:0] burst_end_byte;
    assign burst_end_byte = {1'b0, q.addr} + ({1'b0, AW'(burst_len)} << 2) - (AW+1)'(1);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt) |=> (rd_req && $stable(cur_addr) && $stable(burst_len))); // R13

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (burst_end_byte <= {1'b0, q.ceil})); // R4

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.eof0, q.eof1, q.pald})); // R6
endmodule

// File: rtl/fbdma_fetch.sv
module fbdma_fetch #(
    parameter int unsigned AW             = 32,
    parameter int unsigned DW             = 32,
    parameter int unsigned BURST_MAX_LOG2 = 4,
    parameter int unsigned LENW           = BURST_MAX_LOG2 + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_dual,
    input  logic [1:0]      cfg_load_mode,
    input  logic            cfg_pal_wide,
    input  logic [2:0]      cfg_burst_code,
    input  logic [AW-1:0]   cfg_base0,
    input  logic [AW-1:0]   cfg_ceil0,
    input  logic [AW-1:0]   cfg_base1,
    input  logic [AW-1:0]   cfg_ceil1,
    input  logic [AW-1:0]   cfg_pal_base,
    output logic            rd_req,
    output logic [AW-1:0]   rd_addr,
    output logic [LENW-1:0] rd_len,
    input  logic            rd_gnt,
    input  logic            rd_valid,
    input  logic [DW-1:0]   rd_data,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    output logic            out_pal,
    output logic            out_buf,
    output logic            evt_eof0,
    output logic            evt_eof1,
    output logic            evt_pal_done,
    output logic            busy
);
    localparam int unsigned MAX_WORDS = 1 << BURST_MAX_LOG2;

    logic [AW-1:0]   cur_addr, cur_ceil;
    logic [2:0]      code_q;
    logic [LENW-1:0] burst_len;
    logic            last_burst, burst_done, cnt_load, is_pal, buf_sel;

    fbdma_len_calc #(.AW(AW), .MAX_LOG2(BURST_MAX_LOG2), .LENW(LENW)) u_len (
        .cur_addr  (cur_addr),
        .win_ceil  (cur_ceil),
        .size_code (code_q),
        .burst_len (burst_len),
        .last_burst(last_burst)
    );

    fbdma_beat_cnt #(.LENW(LENW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_len  (burst_len),
        .beat      (rd_valid),
        .burst_done(burst_done)
    );

    fbdma_seq #(.AW(AW), .LENW(LENW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .dual      (cfg_dual),
        .mode      (cfg_load_mode),
        .pal_wide  (cfg_pal_wide),
        .size_code (cfg_burst_code),
        .base0     (cfg_base0),
        .ceil0     (cfg_ceil0),
        .base1     (cfg_base1),
        .ceil1     (cfg_ceil1),
        .pal_base  (cfg_pal_base),
        .rd_gnt    (rd_gnt),
        .burst_done(burst_done),
        .burst_len (burst_len),
        .last_burst(last_burst),
        .rd_req    (rd_req),
        .cur_addr  (cur_addr),
        .cur_ceil  (cur_ceil),
        .code_o    (code_q),
        .cnt_load  (cnt_load),
        .is_pal    (is_pal),
        .buf_sel   (buf_sel),
        .evt_eof0  (evt_eof0),
        .evt_eof1  (evt_eof1),
        .evt_pal   (evt_pal_done),
        .busy      (busy)
    );

    assign rd_addr = cur_addr;
    assign rd_len  = burst_len;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
        logic          pal;
        logic          bsel;
    } ostage_t;

    ostage_t o_q, o_d;

    always_comb begin
        o_d      = o_q;
        o_d.vld  = rd_valid && busy;
        o_d.data = rd_data;
        o_d.pal  = is_pal;
        o_d.bsel = buf_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_data  = o_q.data;
    assign out_pal   = o_q.pal;
    assign out_buf   = o_q.bsel;

    AST_EVT_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_eof0 || evt_eof1 || evt_pal_done) |-> out_valid); // R6

    AST_EOF1_FROM_BUF1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_eof1 |-> out_buf) and (evt_eof0 |-> !out_buf)); // R6

    AST_PALDONE_ON_PAL: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pal_done |-> out_pal); // R7

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((rd_len != '0) && (int'(rd_len) <= int'(MAX_WORDS)))); // R2
endmodule

// File: tb/tb_fbdma_fetch.sv
`timescale 1ns/1ps
module tb_fbdma_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_dual = 1'b0, cfg_pal_wide = 1'b0;
    logic [1:0]  cfg_load_mode = 2'd2;
    logic [2:0]  cfg_burst_code = 3'd0;
    logic [31:0] cfg_base0 = '0, cfg_ceil0 = '0, cfg_base1 = '0, cfg_ceil1 = '0, cfg_pal_base = '0;
    logic        rd_req, rd_gnt = 1'b0, rd_valid = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic [4:0]  rd_len;
    logic        out_valid, out_pal, out_buf, evt_eof0, evt_eof1, evt_pal_done, busy;
    logic [31:0] out_data;

    always #2 clk = ~clk;

    fbdma_fetch dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dual(cfg_dual),
        .cfg_load_mode(cfg_load_mode), .cfg_pal_wide(cfg_pal_wide),
        .cfg_burst_code(cfg_burst_code), .cfg_base0(cfg_base0), .cfg_ceil0(cfg_ceil0),
        .cfg_base1(cfg_base1), .cfg_ceil1(cfg_ceil1), .cfg_pal_base(cfg_pal_base),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len), .rd_gnt(rd_gnt),
        .rd_valid(rd_valid), .rd_data(rd_data), .out_valid(out_valid),
        .out_data(out_data), .out_pal(out_pal), .out_buf(out_buf),
        .evt_eof0(evt_eof0), .evt_eof1(evt_eof1), .evt_pal_done(evt_pal_done), .busy(busy)
    );

    int n_chk = 0, n_err = 0;
    logic [31:0] w_data [0:1023];
    logic        w_pal  [0:1023];
    logic        w_buf  [0:1023];
    int          nw = 0;
    int          ev_k [0:63];
    int          ev_at[0:63];
    int          nev = 0;
    logic [31:0] rq_addr[0:511];
    int          rq_len [0:511];
    int          nreq = 0;
    int          lat = 0;
    bit          gap_on = 0;
    int          hold_err = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // memory responder
    initial begin
        int mstate = 0, wait_c = 0, beat = 0, gap_c = 0, cap_len = 0;
        logic [31:0] cap_addr = '0, seen_a = '0;
        logic [4:0]  seen_l = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mstate = 0; wait_c = 0; rd_gnt = 1'b0; rd_valid = 1'b0;
            end else if (mstate == 0) begin
                rd_valid = 1'b0; rd_gnt = 1'b0;
                if (rd_req) begin
                    if (wait_c == 0) begin seen_a = rd_addr; seen_l = rd_len; end
                    else if (rd_addr != seen_a || rd_len != seen_l) hold_err++;
                    if (wait_c >= lat) begin
                        rd_gnt = 1'b1; cap_addr = rd_addr; cap_len = int'(rd_len);
                        if (nreq < 512) begin rq_addr[nreq] = rd_addr; rq_len[nreq] = int'(rd_len); end
                        nreq++; beat = 0; wait_c = 0; mstate = 1;
                    end else wait_c++;
                end
            end else begin
                rd_gnt = 1'b0;
                if (gap_on && (gap_c % 3 == 2)) rd_valid = 1'b0;
                else begin
                    rd_valid = 1'b1; rd_data = cap_addr + 32'(4 * beat); beat++;
                end
                gap_c++;
                if (beat == cap_len) mstate = 0;
            end
        end
    end

    // output monitor
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (out_valid) begin
                if (nw < 1024) begin w_data[nw] = out_data; w_pal[nw] = out_pal; w_buf[nw] = out_buf; end
                nw++;
            end
            if (nev < 64) begin
                if (evt_eof0)     begin ev_k[nev] = 0; ev_at[nev] = nw; nev++; end
                if (evt_eof1)     begin ev_k[nev] = 1; ev_at[nev] = nw; nev++; end
                if (evt_pal_done) begin ev_k[nev] = 2; ev_at[nev] = nw; nev++; end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    task automatic do_reset();
        cfg_en = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        nw = 0; nev = 0; nreq = 0; hold_err = 0; lat = 0; gap_on = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_ev(input int n, input string tag);
        int c = 0;
        while (nev < n && c < 4000) begin @(negedge clk); c++; end
        if (nev < n) chk({tag, " event timeout"}, nev, n);
    endtask

    task automatic stop_idle();
        int c = 0;
        cfg_en = 1'b0;
        @(negedge clk);
        while (busy && c < 400) begin @(negedge clk); c++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        cfg_en = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {rd_req, out_valid, busy, evt_eof0, evt_eof1, evt_pal_done}, 0);
        do_reset();
        repeat (10) @(negedge clk);
        chk("R1 quiet with enable low", {rd_req, out_valid, busy, evt_eof0, evt_eof1, evt_pal_done}, 0);
    endtask

    task automatic t_single();
        int bad = 0, badb = 0;
        do_reset();
        cfg_dual = 0; cfg_load_mode = 2; cfg_burst_code = 2;
        cfg_base0 = 32'h1000; cfg_ceil0 = 32'h1027;
        cfg_en = 1;
        wait_ev(2, "R5");
        stop_idle();
        chk("R5 first eof kind", ev_k[0], 0);
        chk("R5 second eof kind", ev_k[1], 0);
        chk("R6 eof0 with word 10", ev_at[0], 10);
        chk("R3 second frame length", ev_at[1], 20);
        for (int i = 0; i < 20; i++) begin
            if (w_data[i] != 32'h1000 + 32'(4 * (i % 10))) bad++;
            if (w_buf[i] != 1'b0 || w_pal[i] != 1'b0) badb++;
        end
        chk("R3 word addresses repeat from base", bad, 0);
        chk("R5 buffer tag zero", badb, 0);
        chk("R4 burst lens 4", rq_len[1], 4);
        chk("R4 final burst shortened", rq_len[2], 2);
        chk("R4 next frame restarts full", rq_len[3], 4);
    endtask

    task automatic t_burst();
        for (int c = 0; c < 8; c++) begin
            int exp_w, nb, exp_last;
            do_reset();
            cfg_dual = 0; cfg_load_mode = 2; cfg_burst_code = 3'(c);
            cfg_base0 = 32'h4000; cfg_ceil0 = 32'h404F;
            cfg_en = 1;
            wait_ev(1, "R2");
            stop_idle();
            exp_w = 1 << ((c > 4) ? 4 : c);
            nb = (20 + exp_w - 1) / exp_w;
            exp_last = (20 % exp_w == 0) ? exp_w : 20 % exp_w;
            chk($sformatf("R2 code %0d first burst len", c), rq_len[0], exp_w);
            chk($sformatf("R4 code %0d last burst len", c), rq_len[nb-1], exp_last);
            chk($sformatf("R3 code %0d frame words", c), ev_at[0], 20);
        end
    endtask

    task automatic t_dual();
        int bad = 0;
        do_reset();
        lat = 2; gap_on = 1;
        cfg_dual = 1; cfg_load_mode = 3; cfg_burst_code = 3;
        cfg_base0 = 32'h2000; cfg_ceil0 = 32'h2017;
        cfg_base1 = 32'h3000; cfg_ceil1 = 32'h301F;
        cfg_en = 1;
        wait_ev(4, "R6");
        stop_idle();
        chk("R6 kinds alternate", {ev_k[0][1:0], ev_k[1][1:0], ev_k[2][1:0], ev_k[3][1:0]}, 8'b00_01_00_01);
        chk("R6 eof0 position", ev_at[0], 6);
        chk("R6 eof1 position", ev_at[1], 14);
        chk("R6 second eof1 position", ev_at[3], 28);
        chk("R9 first word from base0", w_data[0], 32'h2000);
        for (int i = 6; i < 14; i++)
            if (w_data[i] != 32'h3000 + 32'(4 * (i - 6)) || w_buf[i] != 1'b1) bad++;
        chk("R6 buffer 1 words tagged", bad, 0);
        chk("R9 no palette word", w_pal[0], 0);
        chk("R13 request held until grant", hold_err, 0);
    endtask

    task automatic t_palette();
        int bad = 0, n0;
        do_reset();
        cfg_dual = 0; cfg_load_mode = 0; cfg_pal_wide = 0; cfg_burst_code = 4;
        cfg_pal_base = 32'h0100; cfg_base0 = 32'h1000; cfg_ceil0 = 32'h100F;
        cfg_en = 1;
        wait_ev(2, "R7");
        stop_idle();
        chk("R7 palette done first", ev_k[0], 2);
        chk("R10 narrow palette 8 words", ev_at[0], 8);
        chk("R7 then eof0 after 4 pixel words", ev_at[1], 12);
        for (int i = 0; i < 8; i++)
            if (w_data[i] != 32'h0100 + 32'(4 * i) || w_pal[i] != 1'b1) bad++;
        chk("R7 palette words flagged", bad, 0);
        chk("R7 first pixel word", {w_pal[8], w_data[8]}, {1'b0, 32'h1000});

        do_reset();
        cfg_load_mode = 1; cfg_pal_wide = 1; cfg_pal_base = 32'h8000;
        cfg_en = 1;
        wait_ev(1, "R8");
        chk("R10 wide palette 128 words", ev_at[0], 128);
        chk("R10 wide palette last word", w_data[127], 32'h81FC);
        n0 = nreq;
        repeat (50) @(negedge clk);
        chk("R8 no requests after palette", nreq, n0);
        chk("R8 idle while enabled", {busy, rd_req}, 0);
        chk("R8 word count unchanged", nw, 128);
        stop_idle();
    endtask

    task automatic t_shadow();
        int bad = 0, at = -1, c = 0;
        do_reset();
        cfg_dual = 0; cfg_load_mode = 2; cfg_burst_code = 2;
        cfg_base0 = 32'h6000; cfg_ceil0 = 32'h602F;
        cfg_en = 1;
        while (nw < 2) @(negedge clk);
        cfg_base0 = 32'h7000; cfg_ceil0 = 32'h700F;
        wait_ev(2, "R11");
        for (int i = 0; i < 12; i++) if (w_data[i] != 32'h6000 + 32'(4 * i)) bad++;
        chk("R11 mid-frame change ignored", bad, 0);
        chk("R11 first frame length", ev_at[0], 12);
        chk("R11 next frame at new base", w_data[12], 32'h7000);
        chk("R11 new window length", ev_at[1], 16);
        while (at < 0 && c < 400) begin
            @(negedge clk); #1;
            if (rd_valid && rd_data == 32'h700C) begin
                at = nw;
                cfg_base0 = 32'h8000; cfg_ceil0 = 32'h8007;
            end
            c++;
        end
        repeat (12) @(negedge clk);
        stop_idle();
        chk("R11 last old word", w_data[at], 32'h700C);
        chk("R11 same-edge change applies next frame", w_data[at+1], 32'h8000);
    endtask

    task automatic t_disable();
        int n0, w0;
        do_reset();
        lat = 2; gap_on = 1;
        cfg_dual = 0; cfg_load_mode = 2; cfg_burst_code = 3;
        cfg_base0 = 32'h9000; cfg_ceil0 = 32'h907F;
        cfg_en = 1;
        while (nw < 3) @(negedge clk);
        cfg_en = 0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R12 burst completed", nw, 8);
        n0 = nreq; w0 = nw;
        repeat (30) @(negedge clk);
        chk("R12 no request after disable", nreq, n0);
        chk("R12 no words after disable", nw, w0);
        chk("R12 idle", {busy, rd_req}, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_burst();
        t_dual();
        t_palette();
        t_shadow();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule